// File: doc/BRIEF.md
# Scoreboard Issue Controller

This block is the central hazard tracker for a processor back end with several independent functional units. A decoded register-to-register instruction arrives with a unit type, a destination register and two source registers, and is accepted through a valid/ready handshake. Decode is split into two phases. The issue phase accepts instructions strictly in program order and refuses one whose unit is occupied or whose destination is already awaiting a result. The operand-read phase lets each accepted instruction fetch its sources as soon as they are valid, independent of the order in which the instructions were accepted.

The controller keeps one status entry per functional unit and a result-status table for the architectural registers. It grants each unit the right to read its operands, receives a completion pulse from each unit when execution ends, and grants write-back one unit per cycle. Write-back is held while an earlier instruction still has to read the old value of that register. Instructions can therefore start and finish out of order, while true, output and anti-dependences are all respected. Operand datapaths, the register file and the units themselves sit outside and are modelled only by the grant and completion signals.

Top module: `sb_issue_ctrl`

## Requirements
- R1: After reset, with no instruction in flight, iss_ready is high, and rd_grant and wb_grant are all zero.
- R2: Unit codes are 0 integer, 1 adder, 2 multiplier, 3 divider. An instruction is accepted only when its unit is idle. iss_ready stays low while the selected unit holds an instruction.
- R3: iss_ready is low while the destination register is the pending destination of any active instruction, even when the selected unit is free.
- R4: An instruction is taken only on a cycle with iss_valid and iss_ready both high. A refused instruction creates no activity: no rd_grant appears for it.
- R5: When neither source is pending, a unit's rd_grant bit is high for exactly one cycle, starting in the cycle right after acceptance.
- R6: When a source is pending from another unit, rd_grant for the waiting unit is withheld until the cycle after that producer's wb_grant.
- R7: A later independent instruction can receive rd_grant while an earlier instruction still waits for its operands.
- R8: A unit's wb_grant can be raised only once an exec_done pulse has been received while that unit executes. The earliest is the cycle after the pulse. An exec_done pulse for a unit that is not executing is ignored.
- R9: A finished unit's wb_grant is withheld while another unit waiting for operand read has a ready, unread source equal to its destination. It is granted in the cycle after that unit's rd_grant.
- R10: At most one wb_grant bit is high per cycle. Among eligible units the lowest index wins.
- R11: In the cycle after a unit's wb_grant, the unit is free and its destination register is no longer pending, so an instruction targeting either is accepted.
- R12: An instruction accepted in the same cycle as the write-back of its source's producer sees that source as ready and gets rd_grant in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| iss_valid | input | 1 | Decoded instruction present |
| iss_ready | output | 1 | Instruction accepted this cycle if valid |
| iss_fu | input | 2 | Functional unit type code |
| iss_dst | input | 4 | Destination register |
| iss_src1 | input | 4 | First source register |
| iss_src2 | input | 4 | Second source register |
| exec_done | input | 4 | Per-unit execution completion pulse |
| rd_grant | output | 4 | Per-unit operand-read grant |
| wb_grant | output | 4 | Per-unit write-back grant, one-hot or zero |

## Verification
The write-back of a producer and the issue of a new instruction that reads the produced register can fall in the same cycle. The bench provokes this by presenting the consumer while the producer's wb_grant is high. It then checks that the consumer's rd_grant appears in the very next cycle, without waiting for a write-back that has already happened. A second collision is checked as well: an operand read and a write-back to that operand's register become possible in the same cycle. The write-back is held one cycle past the rd_grant, and the bench confirms this.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EXEC = 2'd2,
    ST_DONE = 2'd3
  } fu_stage_e;
endpackage

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
  import sb_pkg::*;
#(
  parameter int NUM_FU   = 4,
  parameter int NUM_REGS = 16,
  localparam int TW = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
  localparam int RW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_i,
  input  logic [RW-1:0] alloc_dst_i,
  input  logic [RW-1:0] alloc_src1_i,
  input  logic [RW-1:0] alloc_src2_i,
  input  logic [TW-1:0] alloc_tag1_i,
  input  logic [TW-1:0] alloc_tag2_i,
  input  logic          alloc_wait1_i,
  input  logic          alloc_wait2_i,
  input  logic          wb_fire_i,
  input  logic [TW-1:0] wb_tag_i,
  input  logic          exec_done_i,
  input  logic          wb_grant_i,
  output fu_stage_e     stage_o,
  output logic [RW-1:0] dst_o,
  output logic [RW-1:0] src1_o,
  output logic [RW-1:0] src2_o,
  output logic          rdy1_o,
  output logic          rdy2_o,
  output logic          rd_req_o
);

  fu_stage_e     stage_q, stage_d;
  logic          rdy1_q, rdy1_d, rdy2_q, rdy2_d;
  logic [RW-1:0] dst_q, src1_q, src2_q;
  logic [TW-1:0] tag1_q, tag2_q;
  logic          load_en;

  assign load_en  = (stage_q == ST_IDLE) && alloc_i;
  assign rd_req_o = (stage_q == ST_WAIT) && rdy1_q && rdy2_q;

  always_comb begin
    stage_d = stage_q;
    rdy1_d  = rdy1_q;
    rdy2_d  = rdy2_q;
    unique case (stage_q)
      ST_IDLE: if (alloc_i) begin
        stage_d = ST_WAIT;
        rdy1_d  = !alloc_wait1_i;
        rdy2_d  = !alloc_wait2_i;
      end
      ST_WAIT: if (rd_req_o) begin
        stage_d = ST_EXEC;
        rdy1_d  = 1'b0;
        rdy2_d  = 1'b0;
      end else begin
        if (wb_fire_i && !rdy1_q && (wb_tag_i == tag1_q)) rdy1_d = 1'b1;
        if (wb_fire_i && !rdy2_q && (wb_tag_i == tag2_q)) rdy2_d = 1'b1;
      end
      ST_EXEC: if (exec_done_i) stage_d = ST_DONE;
      ST_DONE: if (wb_grant_i) stage_d = ST_IDLE;
      default: stage_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_IDLE;
      rdy1_q  <= 1'b0;
      rdy2_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      rdy1_q  <= rdy1_d;
      rdy2_q  <= rdy2_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q  <= '0;
      src1_q <= '0;
      src2_q <= '0;
      tag1_q <= '0;
      tag2_q <= '0;
    end else if (load_en) begin
      dst_q  <= alloc_dst_i;
      src1_q <= alloc_src1_i;
      src2_q <= alloc_src2_i;
      tag1_q <= alloc_tag1_i;
      tag2_q <= alloc_tag2_i;
    end
  end

  assign stage_o = stage_q;
  assign dst_o   = dst_q;
  assign src1_o  = src1_q;
  assign src2_o  = src2_q;
  assign rdy1_o  = rdy1_q;
  assign rdy2_o  = rdy2_q;

  AST_READ_THEN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> (stage_q == ST_EXEC)); // R5
  AST_WB_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_grant_i |-> (stage_q == ST_DONE)); // R8
  AST_ALLOC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> (stage_q == ST_IDLE)); // R2

endmodule

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
  parameter int NUM_FU   = 4,
  parameter int NUM_REGS = 16,
  localparam int TW = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
  localparam int RW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           set_i,
  input  logic [RW-1:0]                  set_reg_i,
  input  logic [TW-1:0]                  set_tag_i,
  input  logic                           clr_i,
  input  logic [RW-1:0]                  clr_reg_i,
  input  logic [TW-1:0]                  clr_tag_i,
  output logic [NUM_REGS-1:0]            pend_o,
  output logic [NUM_REGS-1:0][TW-1:0]    prod_o
);

  logic [NUM_REGS-1:0]         pend_q;
  logic [NUM_REGS-1:0][TW-1:0] prod_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic set_here, clr_here, pend_d, en;
    assign set_here = set_i && (set_reg_i == RW'(r));
    assign clr_here = clr_i && (clr_reg_i == RW'(r)) && (prod_q[r] == clr_tag_i);
    assign en       = set_here || clr_here;

    always_comb begin
      pend_d = pend_q[r];
      if (clr_here) pend_d = 1'b0;
      if (set_here) pend_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[r] <= 1'b0;
        prod_q[r] <= '0;
      end else if (en) begin
        pend_q[r] <= pend_d;
        if (set_here) prod_q[r] <= set_tag_i;
      end
    end
  end

  assign pend_o = pend_q;
  assign prod_o = prod_q;

  AST_SET_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |-> !pend_q[set_reg_i]); // R3
  AST_CLR_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |-> (pend_q[clr_reg_i] && (prod_q[clr_reg_i] == clr_tag_i))); // R11

endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb #(
  parameter int NUM_FU = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_FU-1:0] req_i,
  output logic [NUM_FU-1:0] grant_o
);

  always_comb begin
    grant_o = '0;
    for (int i = NUM_FU - 1; i >= 0; i--) begin
      if (req_i[i]) grant_o = NUM_FU'(1) << i;
    end
  end

  AST_WB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R10
  AST_WB_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~req_i) == '0); // R10
  AST_WB_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i != '0) |-> (grant_o != '0)); // R10

endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_FU   = 4,
  parameter int NUM_REGS = 16,
  localparam int TW = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
  localparam int RW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [TW-1:0]     iss_fu,
  input  logic [RW-1:0]     iss_dst,
  input  logic [RW-1:0]     iss_src1,
  input  logic [RW-1:0]     iss_src2,
  input  logic [NUM_FU-1:0] exec_done,
  output logic [NUM_FU-1:0] rd_grant,
  output logic [NUM_FU-1:0] wb_grant
);

  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  fu_stage_e                   stage_v [NUM_FU];
  logic [NUM_FU-1:0][RW-1:0]   dst_v, src1_v, src2_v;
  logic [NUM_FU-1:0]           rdy1_v, rdy2_v, busy_v, wb_req, war_block;
  logic [NUM_REGS-1:0]         pend;
  logic [NUM_REGS-1:0][TW-1:0] prod;
  logic                        issue_fire, wb_fire, wait1, wait2;
  logic [TW-1:0]               wb_tag;
  logic [RW-1:0]               wb_reg;

  assign iss_ready  = rst_int_n && !busy_v[iss_fu] && !pend[iss_dst];
  assign issue_fire = iss_valid && iss_ready;

  always_comb begin
    wb_tag = '0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (wb_grant[i]) wb_tag = TW'(i);
    end
  end
  assign wb_fire = |wb_grant;
  assign wb_reg  = dst_v[wb_tag];

  assign wait1 = pend[iss_src1] && !(wb_fire && (prod[iss_src1] == wb_tag));
  assign wait2 = pend[iss_src2] && !(wb_fire && (prod[iss_src2] == wb_tag));

  always_comb begin
    for (int i = 0; i < NUM_FU; i++) begin
      war_block[i] = 1'b0;
      for (int j = 0; j < NUM_FU; j++) begin
        if ((j != i) && (stage_v[j] == ST_WAIT) &&
            (((src1_v[j] == dst_v[i]) && rdy1_v[j]) ||
             ((src2_v[j] == dst_v[i]) && rdy2_v[j])))
          war_block[i] = 1'b1;
      end
      wb_req[i] = (stage_v[i] == ST_DONE) && !war_block[i];
      busy_v[i] = (stage_v[i] != ST_IDLE);
    end
  end

  for (genvar i = 0; i < NUM_FU; i++) begin : g_fu
    sb_fu_entry #(.NUM_FU(NUM_FU), .NUM_REGS(NUM_REGS)) u_entry (
      .clk          (clk),
      .rst_n        (rst_int_n),
      .alloc_i      (issue_fire && (iss_fu == TW'(i))),
      .alloc_dst_i  (iss_dst),
      .alloc_src1_i (iss_src1),
      .alloc_src2_i (iss_src2),
      .alloc_tag1_i (prod[iss_src1]),
      .alloc_tag2_i (prod[iss_src2]),
      .alloc_wait1_i(wait1),
      .alloc_wait2_i(wait2),
      .wb_fire_i    (wb_fire),
      .wb_tag_i     (wb_tag),
      .exec_done_i  (exec_done[i]),
      .wb_grant_i   (wb_grant[i]),
      .stage_o      (stage_v[i]),
      .dst_o        (dst_v[i]),
      .src1_o       (src1_v[i]),
      .src2_o       (src2_v[i]),
      .rdy1_o       (rdy1_v[i]),
      .rdy2_o       (rdy2_v[i]),
      .rd_req_o     (rd_grant[i])
    );
  end

  sb_reg_status #(.NUM_FU(NUM_FU), .NUM_REGS(NUM_REGS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set_i    (issue_fire),
    .set_reg_i(iss_dst),
    .set_tag_i(iss_fu),
    .clr_i    (wb_fire),
    .clr_reg_i(wb_reg),
    .clr_tag_i(wb_tag),
    .pend_o   (pend),
    .prod_o   (prod)
  );

  sb_wb_arb #(.NUM_FU(NUM_FU)) u_arb (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .req_i  (wb_req),
    .grant_o(wb_grant)
  );

  AST_ISSUE_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_int_n)
    issue_fire |=> busy_v[$past(iss_fu)]); // R2
  AST_ISSUE_MARKS_DST: assert property (@(posedge clk) disable iff (!rst_int_n)
    issue_fire |=> pend[$past(iss_dst)]); // R3
  AST_WB_FREES: assert property (@(posedge clk) disable iff (!rst_int_n)
    wb_fire |=> !pend[$past(wb_reg)]); // R11

endmodule

// File: tb/sim_sb_issue_ctrl.sv
module sim_sb_issue_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       iss_valid;
  logic       iss_ready;
  logic [1:0] iss_fu;
  logic [3:0] iss_dst, iss_src1, iss_src2;
  logic [3:0] exec_done, rd_grant, wb_grant;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  sb_issue_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_fu(iss_fu), .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .exec_done(exec_done), .rd_grant(rd_grant), .wb_grant(wb_grant)
  );

  localparam int FU_INT = 0, FU_ADD = 1, FU_MUL = 2, FU_DIV = 3;

  // vector: unit, destination, source 1, source 2
  localparam logic [13:0] VEC [5] = '{
    {2'd0, 4'd1,  4'd2,  4'd3},
    {2'd1, 4'd4,  4'd1,  4'd1},
    {2'd2, 4'd15, 4'd14, 4'd0},
    {2'd3, 4'd0,  4'd15, 4'd7},
    {2'd2, 4'd9,  4'd9,  4'd9}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic present(input int fu, input int dst, input int s1, input int s2);
    iss_valid = 1'b1;
    iss_fu    = 2'(fu);
    iss_dst   = 4'(dst);
    iss_src1  = 4'(s1);
    iss_src2  = 4'(s2);
    #1;
  endtask

  task automatic drop();
    iss_valid = 1'b0;
    #1;
  endtask

  // unit must be executing: pulse completion, expect write-back, then free it
  task automatic finish(input int fu, input string tag);
    exec_done = 4'(1 << fu);
    step();
    exec_done = '0;
    #1;
    chk(tag, wb_grant, 1 << fu);
    step();
  endtask

  initial begin
    rst_n = 1'b0; iss_valid = 1'b0; iss_fu = '0; iss_dst = '0;
    iss_src1 = '0; iss_src2 = '0; exec_done = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    chk("R1 iss_ready after reset", iss_ready, 1);
    chk("R1 rd_grant after reset", rd_grant, 0);
    chk("R1 wb_grant after reset", wb_grant, 0);

    // table walk: isolated instructions through every unit
    for (int v = 0; v < 5; v++) begin
      int fu;
      fu = int'(VEC[v][13:12]);
      present(fu, int'(VEC[v][11:8]), int'(VEC[v][7:4]), int'(VEC[v][3:0]));
      chk("R2 free unit accepts", iss_ready, 1);
      step();
      drop();
      chk("R5 rd_grant after accept", rd_grant, 1 << fu);
      step();
      chk("R5 rd_grant one cycle", rd_grant, 0);
      chk("R8 no wb before done", wb_grant, 0);
      finish(fu, "R8 wb after done");
      chk("R11 unit free after wb", wb_grant, 0);
    end

    // R8 completion for an idle unit is ignored
    exec_done = 4'b1000;
    step();
    exec_done = '0;
    #1;
    chk("R8 stray exec_done ignored", wb_grant, 0);
    step();
    chk("R8 stray exec_done ignored later", wb_grant, 0);

    // R2 structural stall, R4 refused instruction inert
    present(FU_MUL, 1, 2, 3);
    step();
    drop();
    step();
    present(FU_MUL, 4, 5, 6);
    chk("R2 busy unit refuses", iss_ready, 0);
    step();
    chk("R4 refused gets no grant", rd_grant, 0);
    exec_done = 4'b0100;
    step();
    exec_done = '0;
    #1;
    chk("R8 mul wb", wb_grant, 4);
    step();
    chk("R11 freed unit accepts", iss_ready, 1);
    step();
    drop();
    chk("R5 second mul read", rd_grant, 4);
    step();
    finish(FU_MUL, "R8 second mul wb");

    // R3 output dependence stall
    present(FU_INT, 5, 1, 2);
    step();
    drop();
    step();
    present(FU_ADD, 5, 3, 3);
    chk("R3 pending dst refuses", iss_ready, 0);
    exec_done = 4'b0001;
    step();
    exec_done = '0;
    #1;
    chk("R3 still refused at wb", iss_ready, 0);
    chk("R8 int wb", wb_grant, 1);
    step();
    chk("R11 dst released", iss_ready, 1);
    step();
    drop();
    chk("R5 add read", rd_grant, 2);
    step();
    finish(FU_ADD, "R8 add wb");

    // R6 true dependence, R7 bypass, R10 priority
    present(FU_MUL, 6, 1, 2);
    step();
    drop();
    step();
    present(FU_ADD, 7, 6, 3);
    step();
    drop();
    chk("R6 waiting on producer", rd_grant, 0);
    present(FU_INT, 8, 1, 2);
    step();
    drop();
    chk("R7 later instr reads first", rd_grant, 1);
    step();
    exec_done = 4'b0100;
    step();
    exec_done = '0;
    #1;
    chk("R6 producer wb", wb_grant, 4);
    chk("R6 no read during producer wb", rd_grant, 0);
    step();
    chk("R6 read after producer wb", rd_grant, 2);
    step();
    exec_done = 4'b0011;
    step();
    exec_done = '0;
    #1;
    chk("R10 lowest index first", wb_grant, 1);
    step();
    chk("R10 next unit second", wb_grant, 2);
    step();

    // R9 antidependence hold
    present(FU_MUL, 9, 10, 11);
    step();
    drop();
    step();
    present(FU_ADD, 14, 9, 3);
    step();
    present(FU_INT, 3, 1, 2);
    step();
    drop();
    chk("R9 int reads", rd_grant, 1);
    step();
    exec_done = 4'b0001;
    step();
    exec_done = '0;
    #1;
    chk("R9 wb held for unread source", wb_grant, 0);
    step();
    chk("R9 wb still held", wb_grant, 0);
    exec_done = 4'b0100;
    step();
    exec_done = '0;
    #1;
    chk("R9 unrelated wb proceeds", wb_grant, 4);
    step();
    chk("R9 reader granted", rd_grant, 2);
    chk("R9 held during read", wb_grant, 0);
    step();
    chk("R9 released after read", wb_grant, 1);
    step();
    finish(FU_ADD, "R8 add after war");

    // R12 issue in the producer's write-back cycle
    present(FU_MUL, 5, 1, 2);
    drop();
    present(FU_MUL, 5, 1, 2);
    step();
    drop();
    step();
    exec_done = 4'b0100;
    step();
    exec_done = '0;
    #1;
    chk("R12 producer wb", wb_grant, 4);
    present(FU_ADD, 6, 5, 5);
    chk("R12 accepted in wb cycle", iss_ready, 1);
    step();
    drop();
    chk("R12 read next cycle", rd_grant, 2);
    step();
    finish(FU_ADD, "R12 consumer wb");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule